// File: doc/BRIEF.md
# Grouped Timer Clock Prescaler

This block produces the per-channel count enables for a five-channel timer, all from one peripheral clock. Two 8-bit prescalers each serve a group of channels: the first group is channels 0 and 1, the second group is channels 2, 3 and 4. Behind its group's prescaler, every channel has its own power-of-two divider. A channel's enable fires once every (prescale × divisor) clock cycles. The output is a single-cycle strobe in the peripheral clock domain. No derived clock is generated.

Two configuration words set the block up. The prescaler word has one byte write enable per group. The divider word is written as a whole. Each prescaler field is stored as the ratio minus one. Each divider select is a log2 code, offset by a build-time base of 0 or 1. A code outside the supported range disables its channel. Writes restart the affected counters, so a new ratio is counted from a clean phase. The timer counters, compare logic and interrupts that consume the strobes are not part of this block.

Top module: `gtp_tick_gen`

## Requirements
- R1: While reset is asserted, every tick output is 0. After reset, all configuration fields are 0, so with base 0 every channel ticks on every cycle (prescale 1, divisor 1).
- R2: `pre_wdata[7:0]` is written when `pre_we[0]` is set and serves channels 0 and 1. `pre_wdata[15:8]` is written when `pre_we[1]` is set and serves channels 2, 3 and 4. A field value v divides the clock by v+1.
- R3: The divider select for channel c is `div_wdata[4c+3:4c]`, loaded when `div_we` is set. Code k selects divisor 2^(k+DIV_BASE), and the supported divisors go up to 16.
- R4: A channel with a valid select ticks exactly once every (v+1)×2^(k+DIV_BASE) cycles. Each tick follows a prescaler event of the channel's own group.
- R5: A channel whose code gives log2 divisor above 4 (codes 5..15 with base 0, codes 4..15 with base 1) produces no ticks.
- R6: A prescaler write clears that group's prescaler counter and the divider counters of that group's channels. Counting the cycles after the write edge from 0, a channel's first tick appears in cycle (v+1)×divisor.
- R7: A divider-word write clears every channel's divider counter. With a prescale of 1, a channel's first tick appears in cycle divisor after the write edge.
- R8: A tick is one cycle wide: it is high in two consecutive cycles only when the channel's total ratio is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_we | input | 2 | Per-group write enable for the prescaler word |
| pre_wdata | input | 16 | Prescaler word; one byte per group, each holding the ratio minus one |
| div_we | input | 1 | Write enable for the divider select word |
| div_wdata | input | 20 | Divider select word; 4 bits per channel |
| tick | output | 5 | One-cycle enable strobe per channel |

## Verification
The assertions check these properties on every cycle:
- Each prescaler counter stays within its programmed ratio.
- A prescaler write leaves its counter at zero.
- Every channel tick is preceded by a prescaler event of the channel's own group.
- No tick comes from an unsupported divider code.
- Back-to-back ticks occur only at a total ratio of 1.

The actual tick periods, the restart phase after each kind of write, and the independence of the two groups can only be shown by the bench scenarios. There, a behavioural model counts prescaler events with integer arithmetic and is compared with the outputs on every cycle, and directed measurements of period and first-tick latency are added on top.

// File: rtl/gtp_pkg.sv
package gtp_pkg;
  localparam int unsigned SEL_W    = 4;
  localparam int unsigned MAX_LOG2 = 4;

  // log2 of the divisor selected by a code, given the variant base
  function automatic int unsigned sel_log2(input logic [SEL_W-1:0] code,
                                           input int unsigned base);
    return base + 32'(code);
  endfunction

  function automatic logic sel_valid(input logic [SEL_W-1:0] code,
                                     input int unsigned base);
    return sel_log2(code, base) <= MAX_LOG2;
  endfunction

  // mask of divider counter bits that must all be one for a tick
  function automatic logic [MAX_LOG2-1:0] sel_mask(input logic [SEL_W-1:0] code,
                                                   input int unsigned base);
    int unsigned l;
    l = sel_log2(code, base);
    if (l > MAX_LOG2) return '0;
    return MAX_LOG2'((32'd1 << l) - 32'd1);
  endfunction
endpackage

// File: rtl/gtp_prescaler.sv
module gtp_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PRE_W-1:0] wr_val,
  output logic [PRE_W-1:0] val_o,
  output logic [PRE_W-1:0] cnt_o,
  output logic             tick_o
);
  logic [PRE_W-1:0] val_q, cnt_q;

  assign tick_o = (cnt_q == val_q);
  assign val_o  = val_q;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      cnt_q <= '0;
    end else if (wr_en) begin
      val_q <= wr_val;
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/gtp_chan_div.sv
module gtp_chan_div
  import gtp_pkg::*;
#(
  parameter int unsigned DIV_BASE = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we,
  input  logic [SEL_W-1:0] sel_wdata,
  input  logic             clr,
  input  logic             pre_tick,
  output logic             sel_ok_o,
  output logic             unity_o,
  output logic             tick_o
);
  logic [SEL_W-1:0]    sel_q;
  logic [MAX_LOG2-1:0] dcnt_q;
  logic [MAX_LOG2-1:0] mask;
  logic                hit;

  assign mask     = sel_mask(sel_q, DIV_BASE);
  assign sel_ok_o = sel_valid(sel_q, DIV_BASE);
  assign unity_o  = sel_ok_o && (mask == '0);
  assign hit      = pre_tick && sel_ok_o && ((dcnt_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      dcnt_q <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= hit;
      if (sel_we) sel_q <= sel_wdata;
      if (clr) dcnt_q <= '0;
      else if (pre_tick) dcnt_q <= dcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/gtp_tick_gen.sv
module gtp_tick_gen
  import gtp_pkg::*;
#(
  parameter int unsigned NUM_CH   = 5,
  parameter int unsigned PRE_W    = 8,
  parameter int unsigned SPLIT    = 2,
  parameter int unsigned DIV_BASE = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              pre_we,
  input  logic [2*PRE_W-1:0]      pre_wdata,
  input  logic                    div_we,
  input  logic [NUM_CH*SEL_W-1:0] div_wdata,
  output logic [NUM_CH-1:0]       tick
);
  localparam int unsigned NUM_GRP = 2;

  logic [NUM_GRP-1:0]            pre_tick;
  logic [NUM_GRP-1:0][PRE_W-1:0] pre_val;
  logic [NUM_GRP-1:0][PRE_W-1:0] pre_cnt;
  logic [NUM_CH-1:0]             sel_ok;
  logic [NUM_CH-1:0]             unity;
  logic [NUM_CH-1:0]             ratio_one;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    gtp_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (pre_we[g]),
      .wr_val (pre_wdata[g*PRE_W +: PRE_W]),
      .val_o  (pre_val[g]),
      .cnt_o  (pre_cnt[g]),
      .tick_o (pre_tick[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned GRP = (c < SPLIT) ? 0 : 1;
    gtp_chan_div #(.DIV_BASE(DIV_BASE)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_we    (div_we),
      .sel_wdata (div_wdata[c*SEL_W +: SEL_W]),
      .clr       (div_we | pre_we[GRP]),
      .pre_tick  (pre_tick[GRP]),
      .sel_ok_o  (sel_ok[c]),
      .unity_o   (unity[c]),
      .tick_o    (tick[c])
    );
    assign ratio_one[c] = unity[c] && (pre_val[GRP] == '0);
  end
endmodule

// File: rtl/gtp_tick_gen_chk.sv
module gtp_tick_gen_chk #(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned SPLIT  = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            pre_we,
  input logic [1:0]            pre_tick,
  input logic [1:0][PRE_W-1:0] pre_val,
  input logic [1:0][PRE_W-1:0] pre_cnt,
  input logic [NUM_CH-1:0]     sel_ok,
  input logic [NUM_CH-1:0]     ratio_one,
  input logic [NUM_CH-1:0]     tick
);
  always @(posedge clk) begin
    if (!rst_n) a_r1_quiet_in_reset: assert (tick == '0);
  end

  for (genvar g = 0; g < 2; g++) begin : g_grp_chk
    a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      pre_cnt[g] <= pre_val[g]);
    a_r6_prescale_restart: assert property (@(posedge clk) disable iff (!rst_n)
      pre_we[g] |=> (pre_cnt[g] == '0));
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_chk
    localparam int unsigned GRP = (c < SPLIT) ? 0 : 1;
    a_r4_tick_after_prescale: assert property (@(posedge clk) disable iff (!rst_n)
      tick[c] |-> $past(pre_tick[GRP]));
    a_r5_bad_code_silent: assert property (@(posedge clk) disable iff (!rst_n)
      tick[c] |-> $past(sel_ok[c]));
    a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[c] && $past(tick[c])) |-> $past(ratio_one[c]));
  end
endmodule

bind gtp_tick_gen gtp_tick_gen_chk #(.NUM_CH(NUM_CH), .PRE_W(PRE_W), .SPLIT(SPLIT)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .pre_we    (pre_we),
  .pre_tick  (pre_tick),
  .pre_val   (pre_val),
  .pre_cnt   (pre_cnt),
  .sel_ok    (sel_ok),
  .ratio_one (ratio_one),
  .tick      (tick)
);

// File: tb/gtp_tick_gen_tb_top.sv
module gtp_tick_gen_tb_top;
  timeunit 1ns; timeprecision 1ps;

  localparam int NCH  = 5;
  localparam int BASE = 0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  pre_we = '0;
  logic [15:0] pre_wdata = '0;
  logic        div_we = 1'b0;
  logic [19:0] div_wdata = '0;
  logic [4:0]  tick;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  gtp_tick_gen #(.DIV_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .pre_we(pre_we), .pre_wdata(pre_wdata),
    .div_we(div_we), .div_wdata(div_wdata), .tick(tick)
  );

  // ---------------- behavioural reference model ----------------
  int pv[2], pc[2], sel[NCH], nc[NCH];
  logic [4:0] exp_tick = '0;

  function automatic int grp_of(int c); return (c < 2) ? 0 : 1; endfunction
  function automatic int divisor(int code);
    int l;
    l = code + BASE;
    if (l > 4) return 0;
    return 1 << l;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_tick = '0;
      for (int g = 0; g < 2; g++) begin pv[g] = 0; pc[g] = 0; end
      for (int c = 0; c < NCH; c++) begin sel[c] = 0; nc[c] = 0; end
    end else begin
      bit pt[2];
      for (int g = 0; g < 2; g++) pt[g] = (pc[g] == pv[g]);
      for (int c = 0; c < NCH; c++) begin
        int d;
        d = divisor(sel[c]);
        exp_tick[c] = pt[grp_of(c)] && (d != 0) && ((nc[c] % d) == d - 1);
        if (pt[grp_of(c)]) nc[c]++;
      end
      for (int g = 0; g < 2; g++) pc[g] = pt[g] ? 0 : pc[g] + 1;
      for (int g = 0; g < 2; g++)
        if (pre_we[g]) begin
          pv[g] = int'(pre_wdata[g*8 +: 8]);
          pc[g] = 0;
          for (int c = 0; c < NCH; c++) if (grp_of(c) == g) nc[c] = 0;
        end
      if (div_we)
        for (int c = 0; c < NCH; c++) begin
          sel[c] = int'(div_wdata[c*4 +: 4]);
          nc[c] = 0;
        end
    end
  end

  always @(negedge clk) begin
    vectors++;
    if (tick !== exp_tick) begin
      miscompares++;
      $display("FAIL %s model compare t=%0t: tick act %b exp %b", cur_req, $time, tick, exp_tick);
    end
  end

  // ---------------- directed helpers ----------------
  task automatic check(input string req, input int act, input int exp, input string what);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: act %0d exp %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_pre(input logic [1:0] we, input logic [15:0] d);
    @(negedge clk); pre_we = we; pre_wdata = d;
    @(negedge clk); pre_we = '0;
  endtask

  task automatic wr_div(input logic [19:0] d);
    @(negedge clk); div_we = 1'b1; div_wdata = d;
    @(negedge clk); div_we = 1'b0;
  endtask

  // period between consecutive ticks of one channel, plus width check
  task automatic measure(input int c, input int exp_p, input string req);
    int n;
    n = 0;
    while (tick[c] !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
    @(negedge clk);
    if (exp_p > 1) check("R8", int'(tick[c]), 0, $sformatf("ch%0d tick width", c));
    n = 1;
    while (tick[c] !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
    check(req, n, exp_p, $sformatf("ch%0d period", c));
  endtask

  // cycles from the write edge (first negedge after it is 0) to first tick
  task automatic first_tick(input int c, input int exp_n, input string req);
    int n;
    n = 0;
    while (tick[c] !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
    check(req, n, exp_n, $sformatf("ch%0d first tick latency", c));
  endtask

  task automatic count_ticks(input int c, input int cycles, input int exp_cnt, input string req);
    int k;
    k = 0;
    for (int i = 0; i < cycles; i++) begin @(negedge clk); if (tick[c]) k++; end
    check(req, k, exp_cnt, $sformatf("ch%0d tick count", c));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 5ns);
    miscompares++;
    $display("FAIL watchdog: act timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    check("R1", int'(tick), 0, "ticks in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R1", int'(tick), 31, "post-reset full-rate ticks");
    end

    cur_req = "R2";
    wr_pre(2'b11, {8'd4, 8'd2});
    measure(0, 3, "R2");
    measure(1, 3, "R2");
    measure(2, 5, "R2");
    measure(4, 5, "R2");

    cur_req = "R3";
    wr_div({4'd0, 4'd4, 4'd2, 4'd3, 4'd1});
    measure(0, 6, "R3");
    measure(1, 24, "R4");
    measure(2, 20, "R4");
    measure(3, 80, "R4");
    measure(4, 5, "R3");

    cur_req = "R5";
    wr_div({4'd5, 4'd4, 4'd2, 4'd15, 4'd1});
    count_ticks(4, 200, 0, "R5");
    count_ticks(1, 100, 0, "R5");
    measure(0, 6, "R5");

    cur_req = "R6";
    wr_pre(2'b01, {8'd4, 8'd1});
    first_tick(0, 4, "R6");
    measure(2, 20, "R6");
    wr_pre(2'b10, {8'd0, 8'd1});
    first_tick(2, 4, "R6");

    cur_req = "R7";
    wr_div({4'd0, 4'd0, 4'd3, 4'd0, 4'd2});
    first_tick(2, 8, "R7");
    measure(2, 8, "R7");
    measure(0, 8, "R4");
    count_ticks(3, 10, 10, "R8");

    repeat (20) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule